// File: doc/BRIEF.md
# Serial Trim Configuration Chain

This block holds the startup trim settings for a set of calibration DACs. An external host loads them over three slow wires: a data bit, a data clock and a commit strobe. On each data clock rise the bit is shifted into a long chain. Once every bit is in, a commit strobe copies the whole chain into a holding register in one clock cycle. Only the holding register drives the trim outputs, so the DACs never see the bits while they move through the chain.

The far end of the chain is driven out on a serial pin so the host can check what it shifted in. A separate readback strobe copies the committed holding register back into the chain, so the host can also shift out the values that are in use. All host inputs are asynchronous to the system clock and are synchronised inside the block.

After reset, each trim field holds a value near its expected setting rather than zero. Each field drives a DAC whose top bits are thermometer coded and whose low bits are binary weighted, and the reset value sets both parts to mid-scale.

Top module: `cal_cfg_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, both the chain and `trim_out` take the default pattern, and `cfg_sdo` then shows bit 271 of that pattern.
- R2: The default pattern repeats an 8-bit field 34 times. Bits 7:5 of each field are a thermometer code with the lower two set (011). Bits 4:0 are binary with only bit 4 set. Each field therefore resets to 8'h70.
- R3: Each rising edge of `cfg_sclk`, after synchronisation, shifts the chain up by one position. The synchronised `cfg_sdi` enters bit 0, and `cfg_sdo` always shows chain bit 271.
- R4: Shifting any number of bits leaves `trim_out` unchanged.
- R5: A rising edge of `cfg_commit` copies all 272 chain bits into `trim_out` in a single cycle.
- R6: If a commit edge and a shift edge are seen in the same cycle, `trim_out` takes the chain as it was before that shift. The shift still happens.
- R7: A rising edge of `cfg_readback` loads the chain from the holding register. Shifting then brings the committed bits out on `cfg_sdo`, bit 271 first.
- R8: A readback edge in the same cycle as a commit edge is ignored. A readback edge in the same cycle as a shift edge wins, and that shift is dropped.
- R9: Only rising edges act. A data clock held high for many cycles shifts exactly once, and a held commit strobe commits once.
- R10: A reset applied partway through a load sequence returns both the chain and `trim_out` to the default pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sdi | input | 1 | Serial data from the host (asynchronous) |
| cfg_sclk | input | 1 | Serial data clock from the host (asynchronous) |
| cfg_commit | input | 1 | Commit strobe: copies the chain into the holding register |
| cfg_readback | input | 1 | Readback strobe: copies the holding register into the chain |
| cfg_sdo | output | 1 | Serial readback taken from the end of the chain |
| trim_out | output | 272 | Committed trim bits driving the DACs |

## Verification
Fixed-seed random 272-bit words are shifted in, committed and then read back serially. This shows whether the shift direction and the bit order on `cfg_sdo` are correct, and whether `trim_out` moved before the commit. Directed cases then raise two strobes in the same cycle (commit with shift, readback with commit, readback with shift). Each pairing has an expected outcome that differs from the others, so a wrong priority shows up. Other directed cases hold the data clock high for a long time, which separates edge detection from level sensing, and apply reset in the middle of a load, which shows whether the default pattern reaches both registers.

// File: rtl/cal_cfg_pkg.sv
// Package: shared helpers for the serial trim configuration chain.
// Assumes each trim field has at least one binary bit below its thermometer part.
package cal_cfg_pkg;

    // Reset value of chain bit idx: thermometer part half full, binary part at mid-scale.
    function automatic logic trim_default_bit(int idx, int field_w, int therm_w);
        int pos;
        int bin_w;
        pos   = idx % field_w;
        bin_w = field_w - therm_w;
        if (pos >= bin_w)
            return (pos - bin_w) < ((therm_w + 1) / 2);
        return pos == (bin_w - 1);
    endfunction

endpackage

// File: rtl/cal_sync2.sv
// Two-flop synchroniser for a bus of independent asynchronous single-bit levels.
// Assumes each input bit is held long enough to be sampled; no bus coherence implied.
module cal_sync2 #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] meta_q;

    // Two register stages that resolve metastability on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/cal_sync_edge.sv
// Synchronises asynchronous strobes and gives a one-cycle pulse on each rising edge.
// Assumes strobes stay high and low for more than two system clock cycles.
module cal_sync_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);

    logic [N-1:0] lvl;
    logic [N-1:0] lvl_prev;

    cal_sync2 #(.N(N)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (lvl)
    );

    // Delayed copy of the synchronised level, used to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl;
    end

    assign rise = lvl & ~lvl_prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0)); // R9

endmodule

// File: rtl/cal_shift_chain.sv
// Serial shift chain. A reload from the holding register takes priority over a shift.
// Assumes at most one shift pulse per synchronised host clock edge.
module cal_shift_chain #(
    parameter int W = 272
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] def_pat,
    input  logic         shift_p,
    input  logic         din,
    input  logic         reload_p,
    input  logic [W-1:0] hold_d,
    output logic [W-1:0] q
);

    // Chain update: reset pattern, then reload, then one-position shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= def_pat;
        else if (reload_p) q <= hold_d;
        else if (shift_p)  q <= {q[W-2:0], din};
    end

    AST_CHAIN_RESET: assert property (@(posedge clk)
        !rst_n |=> q == $past(def_pat)); // R1
    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_p && !reload_p) |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0]))); // R3
    AST_CHAIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_p |=> q == $past(hold_d)); // R7

endmodule

// File: rtl/cal_hold_reg.sv
// Parallel holding register that drives the trim outputs; written only on commit or reset.
// Assumes the commit pulse lasts a single cycle.
module cal_hold_reg #(
    parameter int W = 272
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] def_pat,
    input  logic         commit_p,
    input  logic [W-1:0] chain_d,
    output logic [W-1:0] hold_q
);

    // Captures the whole chain in one cycle when a commit pulse arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= def_pat;
        else if (commit_p) hold_q <= chain_d;
    end

    AST_HOLD_RESET: assert property (@(posedge clk)
        !rst_n |=> hold_q == $past(def_pat)); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_p |=> $stable(hold_q)); // R4
    AST_HOLD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_p |=> hold_q == $past(chain_d)); // R5

endmodule

// File: rtl/cal_cfg_chain.sv
// Top level of the serial trim configuration chain: synchronisers, chain, holding register.
// Assumes the host is slow compared with clk and holds each data bit stable across its clock rise.
module cal_cfg_chain
    import cal_cfg_pkg::*;
#(
    parameter int CHAIN_W = 272,
    parameter int FIELD_W = 8,
    parameter int THERM_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sdi,
    input  logic               cfg_sclk,
    input  logic               cfg_commit,
    input  logic               cfg_readback,
    output logic               cfg_sdo,
    output logic [CHAIN_W-1:0] trim_out
);

    localparam int N_STROBE = 3;

    logic [CHAIN_W-1:0]  def_pat;
    logic [CHAIN_W-1:0]  chain_q;
    logic [N_STROBE-1:0] strobe_rise;
    logic                sdi_sync;
    logic                shift_p;
    logic                commit_p;
    logic                rb_p;
    logic                reload_p;

    // Constant reset pattern, one bit per chain position.
    for (genvar gi = 0; gi < CHAIN_W; gi++) begin : g_def
        assign def_pat[gi] = trim_default_bit(gi, FIELD_W, THERM_W);
    end

    cal_sync2 #(.N(1)) i_sdi_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cfg_sdi),
        .q     (sdi_sync)
    );

    cal_sync_edge #(.N(N_STROBE)) i_strobe_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cfg_readback, cfg_commit, cfg_sclk}),
        .rise     (strobe_rise)
    );

    assign shift_p  = strobe_rise[0];
    assign commit_p = strobe_rise[1];
    assign rb_p     = strobe_rise[2];
    // A readback that meets a commit is dropped.
    assign reload_p = rb_p & ~commit_p;

    cal_shift_chain #(.W(CHAIN_W)) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .def_pat  (def_pat),
        .shift_p  (shift_p),
        .din      (sdi_sync),
        .reload_p (reload_p),
        .hold_d   (trim_out),
        .q        (chain_q)
    );

    cal_hold_reg #(.W(CHAIN_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .def_pat  (def_pat),
        .commit_p (commit_p),
        .chain_d  (chain_q),
        .hold_q   (trim_out)
    );

    assign cfg_sdo = chain_q[CHAIN_W-1];

    AST_RB_COMMIT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_p && commit_p && !shift_p) |=> $stable(chain_q)); // R8
    AST_COMMIT_PRESHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_p && shift_p) |=> trim_out == $past(chain_q)); // R6

endmodule

// File: tb/test_cal_cfg_chain.sv
// Self-checking bench: random words mixed with directed strobe clashes, compared with a bench model.
module test_cal_cfg_chain;

    localparam int  W       = 272;
    localparam time CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_sdi = 1'b0;
    logic         cfg_sclk = 1'b0;
    logic         cfg_commit = 1'b0;
    logic         cfg_readback = 1'b0;
    logic         cfg_sdo;
    logic [W-1:0] trim_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [W-1:0] chain_m;
    logic [W-1:0] hold_m;
    logic [W-1:0] defv;

    always #(CLK_PER/2) clk = ~clk;

    cal_cfg_chain i_cal_cfg_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_sdi      (cfg_sdi),
        .cfg_sclk     (cfg_sclk),
        .cfg_commit   (cfg_commit),
        .cfg_readback (cfg_readback),
        .cfg_sdo      (cfg_sdo),
        .trim_out     (trim_out)
    );

    // Expected reset pattern from R2: every 8-bit field is 8'h70.
    function automatic logic [W-1:0] exp_default();
        logic [W-1:0] v;
        for (int f = 0; f < W/8; f++) v[f*8 +: 8] = 8'h70;
        return v;
    endfunction

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] v;
        for (int k = 0; k < W; k += 32) v[k +: 16] = 16'($urandom());
        for (int k = 16; k < W; k += 32) v[k +: 16] = 16'($urandom());
        return v;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // One host data clock period with bit b.
    task automatic shift_bit(logic b);
        cfg_sdi = b;
        wait_cyc(1);
        cfg_sclk = 1'b1;
        wait_cyc(4);
        cfg_sclk = 1'b0;
        wait_cyc(4);
        chain_m = {chain_m[W-2:0], b};
    endtask

    task automatic shift_word(logic [W-1:0] v);
        for (int k = W-1; k >= 0; k--) shift_bit(v[k]);
    endtask

    task automatic commit();
        cfg_commit = 1'b1;
        wait_cyc(5);
        cfg_commit = 1'b0;
        wait_cyc(4);
        hold_m = chain_m;
    endtask

    task automatic readback();
        cfg_readback = 1'b1;
        wait_cyc(5);
        cfg_readback = 1'b0;
        wait_cyc(4);
        chain_m = hold_m;
    endtask

    // Shifts the whole chain out through cfg_sdo, first bit read becomes bit 271.
    task automatic read_chain(output logic [W-1:0] v);
        for (int k = W-1; k >= 0; k--) begin
            v[k] = cfg_sdo;
            shift_bit(1'b0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chain_m = defv;
        hold_m  = defv;
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        logic [W-1:0] va;
        logic [W-1:0] vb;
        logic [W-1:0] rd;
        logic [W-1:0] pre;
        logic         b;
        void'($urandom(32'd2024));
        defv = exp_default();
        do_reset();

        // Reset state.
        chk("R1 trim_out after reset", trim_out, defv);
        chk("R1 sdo after reset", W'(cfg_sdo), W'(defv[W-1]));
        chk("R2 field value 8'h70", W'(trim_out[15:8]), W'(8'h70));

        // Random word shifted in: outputs must stay put until commit.
        va = rand_word();
        shift_word(va);
        chk("R4 trim_out unchanged by shifting", trim_out, defv);
        chk("R3 sdo shows top of shifted word", W'(cfg_sdo), W'(va[W-1]));
        commit();
        chk("R5 commit copies chain", trim_out, va);

        // Readback brings the committed word out, top bit first.
        vb = rand_word();
        shift_word(vb);
        chk("R4 second word not visible", trim_out, va);
        readback();
        chk("R7 sdo after readback", W'(cfg_sdo), W'(va[W-1]));
        read_chain(rd);
        chk("R7 serial readout of committed word", rd, va);
        chk("R3 chain filled with zeros after readout", W'(cfg_sdo), W'(chain_m[W-1]));

        // Commit and shift in the same cycle: hold gets pre-shift chain.
        shift_word(vb);
        pre = chain_m;
        b = ~chain_m[W-1];
        cfg_sdi = b;
        wait_cyc(1);
        cfg_sclk = 1'b1;
        cfg_commit = 1'b1;
        wait_cyc(5);
        cfg_sclk = 1'b0;
        cfg_commit = 1'b0;
        wait_cyc(4);
        chain_m = {chain_m[W-2:0], b};
        hold_m = pre;
        chk("R6 commit with shift takes pre-shift chain", trim_out, pre);
        chk("R6 shift still happens", W'(cfg_sdo), W'(chain_m[W-1]));

        // Readback and commit together: readback dropped.
        shift_word(va);
        cfg_commit = 1'b1;
        cfg_readback = 1'b1;
        wait_cyc(5);
        cfg_commit = 1'b0;
        cfg_readback = 1'b0;
        wait_cyc(4);
        hold_m = chain_m;
        chk("R8 commit applied when clashing with readback", trim_out, va);
        read_chain(rd);
        chk("R8 chain untouched by dropped readback", rd, va);

        // Readback and shift together: readback wins, shift dropped.
        cfg_sdi = 1'b1;
        wait_cyc(1);
        cfg_sclk = 1'b1;
        cfg_readback = 1'b1;
        wait_cyc(5);
        cfg_sclk = 1'b0;
        cfg_readback = 1'b0;
        wait_cyc(4);
        chain_m = hold_m;
        read_chain(rd);
        chk("R8 readback wins over shift", rd, va);

        // Held-high data clock: one shift only.
        cfg_sdi = 1'b1;
        wait_cyc(1);
        cfg_sclk = 1'b1;
        wait_cyc(40);
        cfg_sclk = 1'b0;
        wait_cyc(4);
        chain_m = {chain_m[W-2:0], 1'b1};
        read_chain(rd);
        chk("R9 held clock shifts once", rd, W'(1));
        cfg_commit = 1'b1;
        wait_cyc(40);
        shift_bit(1'b1);
        cfg_commit = 1'b0;
        wait_cyc(4);
        chk("R9 held commit commits once", trim_out, W'(0));

        // Reset partway through loading.
        for (int k = 0; k < 50; k++) shift_bit(1'($urandom()));
        do_reset();
        chk("R10 trim_out back to default", trim_out, defv);
        read_chain(rd);
        chk("R10 chain back to default", rd, defv);

        // A few more random rounds.
        for (int r = 0; r < 3; r++) begin
            va = rand_word();
            shift_word(va);
            commit();
            chk("R5 random commit", trim_out, va);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule